// File: doc/BRIEF.md
# Clock multiplier change sequencer

This control block decides which clock multiplication factor (x1, x2 or x4) is in effect for the system clock. Software writes three fields on a single write strobe: a 2-bit factor request, a switching-mode bit, and a 3-bit settling code. With the mode bit set, the active factor follows the request on the next cycle. With the mode bit clear, the request is only held as pending. In that case it is committed when the clock generator halts on a standby request.

A wake input starts a settling window. The window length is chosen by the settling code. When it ends, the block returns to normal running and raises its ready flag. The block drives the active factor code toward the analog multiplier. It also drives a clock-stopped flag and a clock-ready flag toward the clock gating and the bus masters. The analog multiplier itself, the oscillator and any clock division are outside this block.

Top module: `clkmul_seq`

## Requirements
- R1: After reset the active factor code is 00 (x1), the pending factor is 00, the mode bit is 0 (deferred), the settling code is 0, clk_ready is 1 and clk_stopped is 0.
- R2: Factor codes are 00 = x1, 01 = x2 and 10 = x4. A write carrying code 11 changes neither the pending nor the active factor, but its mode bit and settling code are still stored.
- R3: A write accepted while running, with mode bit 1 and a valid code, sets both the active and the pending factor to that code. The new value appears on the cycle after the strobe.
- R4: A write accepted while running with mode bit 0 updates only the pending factor. The active factor does not change while running.
- R5: A standby request while running moves the block to the stopped state on the next cycle. There, clk_stopped is 1 and clk_ready is 0, and the active factor takes the pending value in that same cycle.
- R6: A wake while stopped starts settling. During settling both flags are 0. clk_ready rises exactly 8 << code cycles after the edge that sampled wake, where code is the stored settling code (8 to 1024 cycles).
- R7: A standby request during settling or while stopped has no effect. A wake while running or settling has no effect.
- R8: Writes while stopped or settling are discarded, and all three stored fields keep their values.
- R9: When a standby request and a write strobe arrive in the same running cycle, the standby wins and the write is discarded.
- R10: clk_stopped and clk_ready are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the three control fields |
| wr_factor | input | 2 | Requested factor code |
| wr_mode | input | 1 | 1 = immediate switch, 0 = deferred to standby |
| wr_settle | input | 3 | Settling-time code |
| stby_req | input | 1 | Request to halt the clock |
| wake | input | 1 | Release from the stopped state |
| factor_act | output | 2 | Active factor code |
| clk_stopped | output | 1 | Clock generator halted |
| clk_ready | output | 1 | Clock running at the active factor and usable |

## Verification
Every result is a register fed straight from the sampled inputs, so each one is due one cycle after its stimulus. This covers the immediate factor change, the commit on a standby request and the entry into settling. The one exception is the ready flag after a wake, which is due exactly 8 << code cycles after the wake edge. A behavioural model in the bench steps once per rising edge and applies the same inputs. The three outputs are compared against it two nanoseconds after every edge. As a result, any result that arrives one cycle early or late shows up as a mismatch in that cycle. Stimuli are changed only after the comparison, well away from the next edge.

// File: rtl/clkmul_pkg.sv
package clkmul_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STOP   = 2'd1,
    ST_SETTLE = 2'd2
  } seq_state_e;

  localparam logic [1:0] FACTOR_RSVD = 2'b11;

endpackage

// File: rtl/clkmul_rst_sync.sv
module clkmul_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/clkmul_regs.sv
module clkmul_regs
  import clkmul_pkg::*;
#(
  parameter int FACTOR_W = 2,
  parameter int SETTLE_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_ok,
  input  logic [FACTOR_W-1:0] wr_factor,
  input  logic                wr_mode,
  input  logic [SETTLE_W-1:0] wr_settle,
  input  logic                commit,
  input  logic                running,
  output logic [FACTOR_W-1:0] factor_act,
  output logic [SETTLE_W-1:0] settle_code
);
  logic [FACTOR_W-1:0] act_q, act_d;
  logic [FACTOR_W-1:0] pend_q, pend_d;
  logic                mode_q, mode_d;
  logic [SETTLE_W-1:0] settle_q, settle_d;
  logic                code_valid;
  logic                ctrl_en;
  logic                pend_en;
  logic                act_en;

  assign code_valid = (wr_factor != FACTOR_W'(FACTOR_RSVD));
  assign ctrl_en    = wr_ok;
  assign pend_en    = wr_ok && code_valid;
  assign act_en     = commit || (pend_en && wr_mode);

  always_comb begin
    mode_d   = mode_q;
    settle_d = settle_q;
    pend_d   = pend_q;
    act_d    = act_q;
    if (ctrl_en) begin
      mode_d   = wr_mode;
      settle_d = wr_settle;
    end
    if (pend_en) pend_d = wr_factor;
    if (act_en) begin
      if (commit) act_d = pend_q;
      else        act_d = wr_factor;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= '0;
      pend_q   <= '0;
      mode_q   <= 1'b0;
      settle_q <= '0;
    end else begin
      if (ctrl_en) begin
        mode_q   <= mode_d;
        settle_q <= settle_d;
      end
      if (pend_en) pend_q <= pend_d;
      if (act_en)  act_q  <= act_d;
    end
  end

  assign factor_act  = act_q;
  assign settle_code = settle_q;

  a_r3_immediate_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wr_mode && wr_factor != FACTOR_W'(FACTOR_RSVD)) |=> (act_q == $past(wr_factor)));

  a_r4_deferred_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !wr_mode) |=> $stable(act_q));

  a_r2_reserved_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wr_factor == FACTOR_W'(FACTOR_RSVD)) |=> ($stable(act_q) && $stable(pend_q)));

  a_r8_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> ($stable(mode_q) && $stable(settle_q) && $stable(pend_q)));

  a_r2_never_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    act_q != FACTOR_W'(FACTOR_RSVD));
endmodule

// File: rtl/clkmul_settle_timer.sv
module clkmul_settle_timer #(
  parameter int SETTLE_W  = 3,
  parameter int BASE_LOG2 = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                active,
  input  logic [SETTLE_W-1:0] code,
  output logic                done
);
  localparam int CNT_W = BASE_LOG2 + (1 << SETTLE_W);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_val;
  logic             cnt_en;

  assign last_val = (CNT_W'(1) << (BASE_LOG2 + int'(code))) - CNT_W'(1);
  assign cnt_en   = start || active;
  assign done     = active && (cnt_q == last_val);

  always_comb begin
    cnt_d = cnt_q;
    if (start)      cnt_d = '0;
    else if (done)  cnt_d = '0;
    else if (active) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q <= last_val));

  a_r6_count_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done && !start) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/clkmul_fsm.sv
module clkmul_fsm
  import clkmul_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_req,
  input  logic       wake,
  input  logic       settle_done,
  output logic       running,
  output logic       commit,
  output logic       settle_start,
  output logic       settling,
  output logic       stopped
);
  seq_state_e state_q, state_d;

  assign running      = (state_q == ST_RUN);
  assign stopped      = (state_q == ST_STOP);
  assign settling     = (state_q == ST_SETTLE);
  assign commit       = running && stby_req;
  assign settle_start = stopped && wake;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (stby_req)    state_d = ST_STOP;
      ST_STOP:   if (wake)        state_d = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_d = ST_RUN;
      default:                    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  a_r5_stop_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (running && stby_req) |=> stopped);

  a_r7_settle_ignores_stby: assert property (@(posedge clk) disable iff (!rst_n)
    (settling && !settle_done) |=> settling);

  a_r7_stop_needs_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !wake) |=> stopped);

  a_r7_run_ignores_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !stby_req) |=> running);
endmodule

// File: rtl/clkmul_seq.sv
module clkmul_seq
  import clkmul_pkg::*;
#(
  parameter int FACTOR_W  = 2,
  parameter int SETTLE_W  = 3,
  parameter int BASE_LOG2 = 3,
  parameter int SYNC_STG  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [FACTOR_W-1:0] wr_factor,
  input  logic                wr_mode,
  input  logic [SETTLE_W-1:0] wr_settle,
  input  logic                stby_req,
  input  logic                wake,
  output logic [FACTOR_W-1:0] factor_act,
  output logic                clk_stopped,
  output logic                clk_ready
);
  logic                rst_i_n;
  logic                running;
  logic                commit;
  logic                settle_start;
  logic                settling;
  logic                stopped;
  logic                settle_done;
  logic                wr_ok;
  logic [SETTLE_W-1:0] settle_code;

  clkmul_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // standby has priority over a write in the same cycle
  assign wr_ok = wr_en && running && !stby_req;

  clkmul_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .stby_req     (stby_req),
    .wake         (wake),
    .settle_done  (settle_done),
    .running      (running),
    .commit       (commit),
    .settle_start (settle_start),
    .settling     (settling),
    .stopped      (stopped)
  );

  clkmul_regs #(.FACTOR_W(FACTOR_W), .SETTLE_W(SETTLE_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .wr_ok       (wr_ok),
    .wr_factor   (wr_factor),
    .wr_mode     (wr_mode),
    .wr_settle   (wr_settle),
    .commit      (commit),
    .running     (running),
    .factor_act  (factor_act),
    .settle_code (settle_code)
  );

  clkmul_settle_timer #(.SETTLE_W(SETTLE_W), .BASE_LOG2(BASE_LOG2)) u_timer (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .start  (settle_start),
    .active (settling),
    .code   (settle_code),
    .done   (settle_done)
  );

  assign clk_stopped = stopped;
  assign clk_ready   = running;

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(clk_stopped && clk_ready));

  a_r9_stby_beats_write: assert property (@(posedge clk) disable iff (!rst_i_n)
    (running && stby_req && wr_en) |=> (clk_stopped && $stable(settle_code)));

  a_r6_no_ready_while_settling: assert property (@(posedge clk) disable iff (!rst_i_n)
    (settling && !settle_done) |=> !clk_ready);
endmodule

// File: tb/clkmul_seq_bench.sv
module clkmul_seq_bench;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_factor;
  logic       wr_mode;
  logic [2:0] wr_settle;
  logic       stby_req;
  logic       wake;
  logic [1:0] factor_act;
  logic       clk_stopped;
  logic       clk_ready;

  int n_tests = 0;
  int n_fail  = 0;
  string cur_req = "R1";

  // behavioural model
  int m_state;   // 0 run, 1 stopped, 2 settling
  int m_act, m_pend, m_mode, m_settle, m_cnt;

  clkmul_seq u_clkmul_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_factor(wr_factor),
    .wr_mode(wr_mode), .wr_settle(wr_settle), .stby_req(stby_req),
    .wake(wake), .factor_act(factor_act), .clk_stopped(clk_stopped),
    .clk_ready(clk_ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic model_reset();
    m_state = 0; m_act = 0; m_pend = 0; m_mode = 0; m_settle = 0; m_cnt = 0;
  endtask

  task automatic model_step();
    if (!rst_n) begin
      model_reset();
    end else begin
      case (m_state)
        0: begin
          if (stby_req) begin
            m_state = 1;
            m_act   = m_pend;
          end else if (wr_en) begin
            m_mode   = int'(wr_mode);
            m_settle = int'(wr_settle);
            if (wr_factor != 2'b11) begin
              m_pend = int'(wr_factor);
              if (wr_mode) m_act = int'(wr_factor);
            end
          end
        end
        1: if (wake) begin m_state = 2; m_cnt = 0; end
        default: begin
          if (m_cnt == (8 << m_settle) - 1) m_state = 0;
          else m_cnt = m_cnt + 1;
        end
      endcase
    end
  endtask

  task automatic check(string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #2;
    check("factor_act", int'(factor_act), m_act);
    check("clk_stopped", int'(clk_stopped), (m_state == 1) ? 1 : 0);
    check("clk_ready", int'(clk_ready), (m_state == 0) ? 1 : 0);
    if (clk_stopped && clk_ready) check("R10 exclusive flags", 1, 0);
  endtask

  task automatic idle();
    wr_en = 0; stby_req = 0; wake = 0;
  endtask

  task automatic write(input logic [1:0] f, input logic m, input logic [2:0] s);
    wr_en = 1; wr_factor = f; wr_mode = m; wr_settle = s;
    tick();
    idle();
  endtask

  task automatic pulse_stby();
    stby_req = 1; tick(); idle();
  endtask

  task automatic pulse_wake();
    wake = 1; tick(); idle();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // watchdog
  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle();
    wr_factor = 0; wr_mode = 0; wr_settle = 0;
    rst_n = 0;
    model_reset();
    #1;
    cur_req = "R1";
    run(3);
    rst_n = 1;
    run(4);

    cur_req = "R3";               // immediate x2 then x4
    write(2'b01, 1'b1, 3'd0); run(2);
    write(2'b10, 1'b1, 3'd0); run(2);

    cur_req = "R2";               // reserved code leaves factor
    write(2'b11, 1'b1, 3'd1); run(2);
    write(2'b00, 1'b1, 3'd0); run(1);

    cur_req = "R4";               // deferred x4
    write(2'b10, 1'b0, 3'd0); run(3);

    cur_req = "R5";               // commit on stop
    pulse_stby(); run(3);

    cur_req = "R8";               // writes while stopped dropped
    write(2'b01, 1'b1, 3'd5); run(1);
    cur_req = "R7";
    pulse_stby(); run(2);

    cur_req = "R6";               // settle code 0 = 8 cycles
    pulse_wake();
    cur_req = "R8";
    write(2'b00, 1'b1, 3'd6);
    cur_req = "R7";
    pulse_stby(); pulse_wake();
    cur_req = "R6";
    run(10);

    cur_req = "R7";               // wake in run ignored
    pulse_wake(); run(2);

    cur_req = "R4";               // deferred x2, settle code 2 = 32
    write(2'b01, 1'b0, 3'd2); run(2);
    cur_req = "R9";               // stby and write together
    wr_en = 1; wr_factor = 2'b10; wr_mode = 1; wr_settle = 3'd7; stby_req = 1;
    tick(); idle();
    run(2);
    cur_req = "R6";
    pulse_wake(); run(36);

    cur_req = "R2";               // reserved in deferred mode, settle code 7
    write(2'b11, 1'b0, 3'd7); run(1);
    cur_req = "R5";
    pulse_stby(); run(1);
    cur_req = "R6";
    pulse_wake(); run(1030);

    cur_req = "R1";               // asynchronous reset mid-run
    write(2'b10, 1'b1, 3'd3); run(1);
    #1 rst_n = 0;
    model_reset();
    run(2);
    rst_n = 1;
    run(4);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule